// File: doc/BRIEF.md
# Thread Context Ring Matcher

This combinational block decides whether one hardware thread's interrupt context is the destination of an incoming notification, and if so, at which privilege ring. It sees the word-2 value of each of the thread's four context rings (physical, hypervisor pool, OS, user) as big-endian words, the thread's hardwired CAM value, and the notification fields. It answers with a match flag, a 2-bit ring code and an unsupported flag.

A notification either names a specific target, selected by a block and an index, or, when the format bit is set, is a user-level event-based-branch notification that also carries a logical server number. A specific-target notification with the ignore bit set asks for logical-server selection. This block does not implement that mode; it flags the request as unsupported. One instance sits beside each thread's context; the surrounding logic handles priority and delivery.

Top module: `ctx_ring_matcher`

## Requirements
- R1: With fmt_i=0 and ignore_i=1, unsupported_o is 1, match_o is 0 and ring_o is 0, whatever the ring words hold.
- R2: With fmt_i=0 and ignore_i=0, the physical ring hits when its native valid bit (bit 31) is set and hw_cam_i equals the target CAM. The block then drives match_o=1 and ring_o=3.
- R3: With fmt_i=0 and ignore_i=0, the pool ring hits when its valid bit is set and its CAM field (native low CAM_W bits) equals the target CAM. The block then drives ring_o=2.
- R4: With fmt_i=0 and ignore_i=0, the OS ring hits when its valid bit is set and its CAM field equals the target CAM. The block then drives ring_o=1.
- R5: When several rings hit for a specific target, the result follows the priority physical > pool > OS.
- R6: With fmt_i=1, a match (ring_o=0) requires all four conditions: OS valid is set, the OS CAM equals the target, user valid is set, and the user ring's logical server field (native low LS_W bits) equals lsrv_i.
- R7: With fmt_i=1, ignore_i and the physical and pool rings have no effect, and unsupported_o stays 0.
- R8: Each ring word arrives big-endian: bits [7:0] carry the most significant byte. The block byte-swaps every word before it reads any field.
- R9: When no rule holds, match_o=0 and ring_o=0.
- R10: The target CAM is {tgt_blk_i, tgt_idx_i}, with the block above the index. Both are compared in full, so a difference in either one alone prevents a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_i | input | 1 | Format: 0 specific target, 1 user event-based branch |
| ignore_i | input | 1 | Requests logical-server selection in format 0 |
| tgt_blk_i | input | BLK_W | Target block number |
| tgt_idx_i | input | IDX_W | Target index |
| lsrv_i | input | LS_W | Requested logical server number |
| hw_cam_i | input | BLK_W+IDX_W | Thread's hardwired CAM value |
| phys_w2_i | input | 32 | Physical ring word 2, big-endian |
| pool_w2_i | input | 32 | Hypervisor pool ring word 2, big-endian |
| os_w2_i | input | 32 | OS ring word 2, big-endian |
| user_w2_i | input | 32 | User ring word 2, big-endian |
| match_o | output | 1 | Notification targets this thread |
| ring_o | output | 2 | Matched ring: 0 user, 1 OS, 2 pool, 3 physical |
| unsupported_o | output | 1 | Logical-server request not handled |

## Verification
The block holds no state, so a fault shows as a wrong output code in the same cycle as the stimulus that triggers it. Examples are a swapped priority order, a missed byte swap, or a compare against the wrong field. The bench therefore compares every output against an independent model on every clock. It uses directed cases for each ring, for the priority order and for the format-1 conditions. It also uses biased random words in which valid bits and matching CAM fields are set often, so that several rings can hit together.

// File: rtl/ctx_match_pkg.sv
package ctx_match_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_RINGS = 4;
  localparam int VALID_BIT = 31;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  // big-endian word: bits [7:0] hold the most significant byte
  function automatic logic [WORD_W-1:0] be_to_native(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/ctx_word_unpack.sv
module ctx_word_unpack
  import ctx_match_pkg::*;
#(
  parameter int CAM_W = 23,
  parameter int LS_W  = 16
) (
  input  logic [WORD_W-1:0] w_be_i,
  output logic              valid_o,
  output logic [CAM_W-1:0]  cam_o,
  output logic [LS_W-1:0]   lsrv_o
);

  logic [WORD_W-1:0] native;
  logic              unused_native;

  assign native        = be_to_native(w_be_i);
  assign valid_o       = native[VALID_BIT];
  assign cam_o         = native[CAM_W-1:0];
  assign lsrv_o        = native[LS_W-1:0];
  assign unused_native = ^native;

endmodule

// File: rtl/ctx_ring_cmp.sv
module ctx_ring_cmp
  import ctx_match_pkg::*;
#(
  parameter int CAM_W = 23,
  parameter int LS_W  = 16
) (
  input  logic                 fmt_i,
  input  logic                 ignore_i,
  input  logic [CAM_W-1:0]     tgt_cam_i,
  input  logic [CAM_W-1:0]     hw_cam_i,
  input  logic [LS_W-1:0]      lsrv_i,
  input  logic [NUM_RINGS-1:0] valid_i,
  input  logic [CAM_W-1:0]     pool_cam_i,
  input  logic [CAM_W-1:0]     os_cam_i,
  input  logic [LS_W-1:0]      user_lsrv_i,
  output logic [NUM_RINGS-1:0] hit_o,
  output logic                 ls_req_o
);

  logic specific;
  logic os_cam_eq;

  assign ls_req_o  = !fmt_i && ignore_i;
  assign specific  = !fmt_i && !ignore_i;
  assign os_cam_eq = valid_i[RING_OS] && (os_cam_i == tgt_cam_i);

  always_comb begin
    hit_o            = '0;
    hit_o[RING_PHYS] = specific && valid_i[RING_PHYS] && (hw_cam_i == tgt_cam_i);
    hit_o[RING_POOL] = specific && valid_i[RING_POOL] && (pool_cam_i == tgt_cam_i);
    hit_o[RING_OS]   = specific && os_cam_eq;
    hit_o[RING_USER] = fmt_i && os_cam_eq && valid_i[RING_USER] &&
                       (user_lsrv_i == lsrv_i);
  end

endmodule

// File: rtl/ctx_ring_select.sv
module ctx_ring_select
  import ctx_match_pkg::*;
(
  input  logic [NUM_RINGS-1:0] hit_i,
  output logic                 match_o,
  output logic [1:0]           ring_o
);

  // higher ring index has precedence
  always_comb begin
    match_o = 1'b0;
    ring_o  = RING_USER;
    for (int r = 0; r < NUM_RINGS; r++) begin
      if (hit_i[r]) begin
        match_o = 1'b1;
        ring_o  = 2'(r);
      end
    end
  end

endmodule

// File: rtl/ctx_ring_matcher.sv
module ctx_ring_matcher
  import ctx_match_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 19,
  parameter int LS_W  = 16
) (
  input  logic                   fmt_i,
  input  logic                   ignore_i,
  input  logic [BLK_W-1:0]       tgt_blk_i,
  input  logic [IDX_W-1:0]       tgt_idx_i,
  input  logic [LS_W-1:0]        lsrv_i,
  input  logic [BLK_W+IDX_W-1:0] hw_cam_i,
  input  logic [WORD_W-1:0]      phys_w2_i,
  input  logic [WORD_W-1:0]      pool_w2_i,
  input  logic [WORD_W-1:0]      os_w2_i,
  input  logic [WORD_W-1:0]      user_w2_i,
  output logic                   match_o,
  output logic [1:0]             ring_o,
  output logic                   unsupported_o
);

  localparam int CAM_W = BLK_W + IDX_W;

  logic [NUM_RINGS-1:0][WORD_W-1:0] w_be;
  logic [NUM_RINGS-1:0]             valid;
  logic [NUM_RINGS-1:0][CAM_W-1:0]  cam;
  logic [NUM_RINGS-1:0][LS_W-1:0]   lsrv;
  logic [NUM_RINGS-1:0]             hit;
  logic [CAM_W-1:0]                 tgt_cam;
  logic                             ls_req;
  logic                             unused_fields;

  assign w_be[RING_PHYS] = phys_w2_i;
  assign w_be[RING_POOL] = pool_w2_i;
  assign w_be[RING_OS]   = os_w2_i;
  assign w_be[RING_USER] = user_w2_i;
  assign tgt_cam         = {tgt_blk_i, tgt_idx_i};

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_unpack
    ctx_word_unpack #(.CAM_W(CAM_W), .LS_W(LS_W)) u_unpack (
      .w_be_i  (w_be[g]),
      .valid_o (valid[g]),
      .cam_o   (cam[g]),
      .lsrv_o  (lsrv[g])
    );
  end

  assign unused_fields = ^{cam[RING_PHYS], cam[RING_USER],
                           lsrv[RING_PHYS], lsrv[RING_POOL], lsrv[RING_OS]};

  ctx_ring_cmp #(.CAM_W(CAM_W), .LS_W(LS_W)) u_cmp (
    .fmt_i       (fmt_i),
    .ignore_i    (ignore_i),
    .tgt_cam_i   (tgt_cam),
    .hw_cam_i    (hw_cam_i),
    .lsrv_i      (lsrv_i),
    .valid_i     (valid),
    .pool_cam_i  (cam[RING_POOL]),
    .os_cam_i    (cam[RING_OS]),
    .user_lsrv_i (lsrv[RING_USER]),
    .hit_o       (hit),
    .ls_req_o    (ls_req)
  );

  ctx_ring_select u_sel (
    .hit_i   (hit),
    .match_o (match_o),
    .ring_o  (ring_o)
  );

  assign unsupported_o = ls_req;

  always_comb begin
    if (unsupported_o) assert_ls_nomatch_R1: assert (!match_o);
    if (match_o) assert_sel_hit_R5: assert (hit[ring_o]);
    if (match_o && ring_o != RING_PHYS) assert_no_higher_R5: assert (!hit[RING_PHYS]);
    if (fmt_i && match_o) assert_user_ring_R6: assert (ring_o == RING_USER);
    if (fmt_i) assert_fmt1_supported_R7: assert (!unsupported_o);
    if (!match_o) assert_idle_code_R9: assert (ring_o == RING_USER && hit == '0);
    assert_hit_onehot_R6: assert (!(hit[RING_USER] && |hit[NUM_RINGS-1:1]));
  end

endmodule

// File: tb/sim_ctx_ring_matcher.sv
module sim_ctx_ring_matcher;

  localparam int BLK_W = 4;
  localparam int IDX_W = 19;
  localparam int LS_W  = 16;
  localparam int CAM_W = BLK_W + IDX_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             fmt, ign;
  logic [BLK_W-1:0] blk;
  logic [IDX_W-1:0] idx;
  logic [LS_W-1:0]  ls;
  logic [CAM_W-1:0] hwc;
  logic [31:0]      wp, wl, wo, wu;
  logic             match;
  logic [1:0]       ring;
  logic             unsup;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ctx_ring_matcher #(.BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W)) u0 (
    .fmt_i(fmt), .ignore_i(ign), .tgt_blk_i(blk), .tgt_idx_i(idx),
    .lsrv_i(ls), .hw_cam_i(hwc), .phys_w2_i(wp), .pool_w2_i(wl),
    .os_w2_i(wo), .user_w2_i(wu), .match_o(match), .ring_o(ring),
    .unsupported_o(unsup)
  );

  // native value -> big-endian lane order (swap is its own inverse)
  function automatic logic [31:0] be(input logic [31:0] n);
    return {n[7:0], n[15:8], n[23:16], n[31:24]};
  endfunction

  function automatic logic [31:0] mk(input bit v, input logic [CAM_W-1:0] c);
    logic [31:0] n;
    n = 32'(c);
    n[31] = v;
    return be(n);
  endfunction

  function automatic logic [31:0] mku(input bit v, input logic [LS_W-1:0] l);
    logic [31:0] n;
    n = 32'(l);
    n[31] = v;
    return be(n);
  endfunction

  // reference: returns {unsup, match, ring}
  function automatic logic [3:0] model();
    logic [31:0] np, nl, no, nu;
    int t;
    np = be(wp); nl = be(wl); no = be(wo); nu = be(wu);
    t  = int'({blk, idx});
    if (!fmt && ign) return 4'b1000;
    if (!fmt) begin
      if (np[31] && int'(hwc) == t) return 4'b0111;
      if (nl[31] && int'(nl[CAM_W-1:0]) == t) return 4'b0110;
      if (no[31] && int'(no[CAM_W-1:0]) == t) return 4'b0101;
      return 4'b0000;
    end
    if (no[31] && int'(no[CAM_W-1:0]) == t && nu[31] && nu[LS_W-1:0] == ls)
      return 4'b0100;
    return 4'b0000;
  endfunction

  task automatic check(input string tag);
    logic [3:0] exp;
    @(posedge clk);
    exp = model();
    checks++;
    if ({unsup, match, ring} !== exp) begin
      fails++;
      $display("FAIL %s: got unsup=%b match=%b ring=%0d, expected unsup=%b match=%b ring=%0d",
               tag, unsup, match, ring, exp[3], exp[2], exp[1:0]);
    end
  endtask

  task automatic drive(input bit f, input bit i, input logic [CAM_W-1:0] tgt,
                       input logic [CAM_W-1:0] h, input logic [LS_W-1:0] l,
                       input logic [31:0] p, input logic [31:0] q,
                       input logic [31:0] o, input logic [31:0] u);
    @(negedge clk);
    fmt = f; ign = i; {blk, idx} = tgt; hwc = h; ls = l;
    wp = p; wl = q; wo = o; wu = u;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [CAM_W-1:0] t, o1;
    logic [LS_W-1:0]  l1;
    t  = 23'h5_1234;
    o1 = 23'h2_0F0F;
    l1 = 16'hBEEF;

    drive(0, 0, '0, '0, '0, '0, '0, '0, '0);           check("R9 all-zero idle");
    drive(0, 0, t, o1, '0, '0, '0, '0, '0);            check("R9 nothing valid");
    drive(0, 1, t, t, '0, mk(1,t), mk(1,t), mk(1,t), '0); check("R1 logical server");
    drive(0, 0, t, t, '0, mk(1,o1), '0, '0, '0);       check("R2 physical hit");
    drive(0, 0, t, o1, '0, mk(1,t), '0, '0, '0);       check("R2 phys cam mismatch");
    drive(0, 0, t, o1, '0, '0, mk(1,t), '0, '0);       check("R3 pool hit");
    drive(0, 0, t, o1, '0, '0, mk(0,t), '0, '0);       check("R3 pool invalid");
    drive(0, 0, t, o1, '0, '0, '0, mk(1,t), '0);       check("R4 os hit");
    drive(0, 0, t, t, '0, mk(1,o1), mk(1,t), mk(1,t), '0); check("R5 phys over all");
    drive(0, 0, t, o1, '0, '0, mk(1,t), mk(1,t), '0);  check("R5 pool over os");
    drive(1, 0, t, o1, l1, '0, '0, mk(1,t), mku(1,l1)); check("R6 user hit");
    drive(1, 0, t, o1, l1, '0, '0, mk(1,t), mku(0,l1)); check("R6 user invalid");
    drive(1, 0, t, o1, l1, '0, '0, mk(0,t), mku(1,l1)); check("R6 os invalid");
    drive(1, 0, t, o1, l1 ^ 16'h1, '0, '0, mk(1,t), mku(1,l1)); check("R6 lsrv mismatch");
    drive(1, 0, t, t, l1, mk(1,o1), mk(1,t), '0, '0);  check("R7 phys/pool ignored");
    drive(1, 1, t, o1, l1, '0, '0, mk(1,t), mku(1,l1)); check("R7 ignore bit ignored");
    drive(0, 0, t, o1, '0, '0, '0, {be(32'(t)) | 32'h0000_0080} ^ 32'h80 | 32'h8000_0000, '0);
    check("R8 valid in wrong lane");
    drive(0, 0, t, o1, '0, '0, '0, 32'(t) | 32'h8000_0000, '0); check("R8 unswapped word");
    drive(0, 0, t, o1, '0, '0, mk(1, t ^ 23'h40_0000), '0, '0); check("R10 block differs");
    drive(0, 0, t, o1, '0, '0, mk(1, t ^ 23'h04_0000), '0, '0); check("R10 index msb differs");

    for (int n = 0; n < 3000; n++) begin
      logic [CAM_W-1:0] tg, c;
      bit f, i;
      f  = ($urandom % 3) == 0;
      i  = ($urandom % 4) == 0;
      tg = CAM_W'($urandom);
      c  = ($urandom % 2) ? tg : CAM_W'($urandom);
      l1 = LS_W'($urandom % 4);
      drive(f, i, tg, c, LS_W'($urandom % 4),
            mk($urandom % 2 == 1, ($urandom % 2) ? tg : CAM_W'($urandom)),
            mk($urandom % 2 == 1, ($urandom % 2) ? tg : CAM_W'($urandom)),
            mk($urandom % 2 == 1, ($urandom % 2) ? tg : CAM_W'($urandom)),
            mku($urandom % 2 == 1, l1));
      check("R5 R6 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule